// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block decides, for each memory access, whether the access is served by internal RAM or forwarded to the external bus. It covers the upper part of a 20-bit address space. The area from 0xC0000 to 0xEFFFF is split into twelve 16 KB segments. The area from 0xF0000 to 0xFFFFF is one 64 KB segment. Each segment has its own read-enable bit and its own write-enable bit, so that ROM contents can be copied into RAM and then served from RAM ("shadowed") for reads, writes, or both.

Four control bytes hold the enable bits. They are loaded through a byte write port with a two-bit index. The routing decision is combinational from the access address, the access direction and the registered control bytes. The block also produces two summary flags, one for reads and one for writes, that show whether any segment at or above 0xE0000 is shadowed. A further output, the SMRAM enable, is taken from one bit of the last control byte.

Top module: `shadow_route_dec`

## Requirements
- R1: After reset, all four control bytes are zero. Every access from 0xC0000 upward routes to the external bus (route_int = 0), and bios_rd_shadow, bios_wr_shadow and smram_en are all 0.
- R2: Any access below 0xC0000 routes internally (route_int = 1), whatever the control bytes hold.
- R3: Control bytes with index 0, 1 and 2 each hold four bit pairs. Pair p (bits 2p+1:2p) of byte k controls the 16 KB segment that starts at 0xC0000 + 0x4000 × (4k + p). No other segment is affected by that pair.
- R4: Inside a pair, the lower (even) bit set to 1 routes writes internally; set to 0, writes go to the external bus.
- R5: Inside a pair, the upper (odd) bit set to 1 routes reads internally; set to 0, reads go to the external bus.
- R6: Bits 1:0 of control byte 3 control the whole 64 KB segment 0xF0000 to 0xFFFFF. Bit 0 controls writes and bit 1 controls reads, with the same meaning as in R4 and R5.
- R7: bios_wr_shadow is 1 exactly when the write bit of at least one segment at or above 0xE0000 is set. These write bits are the even bits of byte 2 and bit 0 of byte 3.
- R8: bios_rd_shadow is 1 exactly when the read bit of at least one segment at or above 0xE0000 is set. These read bits are the odd bits of byte 2 and bit 1 of byte 3.
- R9: smram_en equals bit 7 of control byte 3.
- R10: A control byte is written on the rising clock edge where cfg_we = 1. During that cycle the routing output still reflects the old value, and it reflects the new value from the following cycle on. When cfg_we = 0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_idx | input | 2 | Control byte index, 0 to 3 |
| cfg_wdata | input | 8 | Control byte write data |
| acc_addr | input | 20 | Address of the current access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| route_int | output | 1 | 1 = internal RAM, 0 = external bus |
| bios_rd_shadow | output | 1 | Read shadowing active at or above 0xE0000 |
| bios_wr_shadow | output | 1 | Write shadowing active at or above 0xE0000 |
| smram_en | output | 1 | SMRAM enable |

## Verification
A control byte update and a lookup into the segment that this update changes can fall in the same cycle. The bench provokes this by presenting the write strobe and the matching access address together between two clock edges. It checks that the routing still follows the old setting before the edge and follows the new one after the edge. A companion case keeps the data on the write port but holds the strobe low, and confirms that the routing and the flags stay unchanged.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;
  // per-segment access attribute
  typedef struct packed {
    logic rd;
    logic wr;
  } seg_attr_t;

  localparam int unsigned PAIRS_PER_BYTE = 4;
  localparam int unsigned CTRL_W         = 8;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_dec_pkg::*;
#(
  parameter int unsigned CTRL_BYTES = 4,
  localparam int unsigned IDX_W = $clog2(CTRL_BYTES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [CTRL_W-1:0]                   wdata,
  output logic [CTRL_BYTES-1:0][CTRL_W-1:0]   ctrl
);
  logic [CTRL_BYTES-1:0][CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CTRL_BYTES-1:0]             byte_en;

  // per-byte clock enables
  generate
    for (genvar b = 0; b < CTRL_BYTES; b++) begin : g_en
      assign byte_en[b] = we && (idx == IDX_W'(b));
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    for (int b = 0; b < CTRL_BYTES; b++) begin
      if (byte_en[b]) ctrl_d[b] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/shadow_seg_attr.sv
module shadow_seg_attr
  import shadow_dec_pkg::*;
#(
  parameter int unsigned CTRL_BYTES = 4,
  parameter int unsigned N_SMALL    = 12,
  parameter int unsigned BIOS_FIRST = 8,
  parameter int unsigned SMRAM_BIT  = 7,
  localparam int unsigned N_SEG = N_SMALL + 1
) (
  input  logic [CTRL_BYTES-1:0][CTRL_W-1:0] ctrl,
  output seg_attr_t [N_SEG-1:0]             attr,
  output logic                              bios_rd,
  output logic                              bios_wr,
  output logic                              smram
);
  localparam int unsigned LAST = CTRL_BYTES - 1;

  // small segments: two bits each, four per byte
  generate
    for (genvar s = 0; s < N_SMALL; s++) begin : g_small
      localparam int unsigned BYTE = s / PAIRS_PER_BYTE;
      localparam int unsigned PAIR = s % PAIRS_PER_BYTE;
      assign attr[s].wr = ctrl[BYTE][2*PAIR];
      assign attr[s].rd = ctrl[BYTE][2*PAIR+1];
    end
  endgenerate

  // single top segment from the last byte
  assign attr[N_SMALL].wr = ctrl[LAST][0];
  assign attr[N_SMALL].rd = ctrl[LAST][1];

  always_comb begin
    bios_rd = 1'b0;
    bios_wr = 1'b0;
    for (int s = BIOS_FIRST; s < N_SEG; s++) begin
      bios_rd = bios_rd | attr[s].rd;
      bios_wr = bios_wr | attr[s].wr;
    end
  end

  assign smram = ctrl[LAST][SMRAM_BIT];

  logic unused_bits;
  assign unused_bits = ^ctrl[LAST][SMRAM_BIT-1:2];
endmodule

// File: rtl/shadow_addr_sel.sv
module shadow_addr_sel
  import shadow_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SEG_SHIFT = 14,
  parameter int unsigned N_SMALL   = 12,
  localparam int unsigned N_SEG  = N_SMALL + 1,
  localparam int unsigned HI_W   = ADDR_W - SEG_SHIFT,
  localparam int unsigned SUB_W  = HI_W - 2,
  localparam int unsigned SEL_W  = $clog2(N_SEG)
) (
  input  logic [HI_W-1:0]        addr_hi,
  input  logic                   is_write,
  input  seg_attr_t [N_SEG-1:0]  attr,
  output logic                   route_int
);
  logic             in_zone;
  logic             in_top;
  logic [SUB_W-1:0] sub_idx;
  logic [SEL_W-1:0] sel;
  seg_attr_t        hit;

  assign in_zone = &addr_hi[HI_W-1 -: 2];
  assign sub_idx = addr_hi[SUB_W-1:0];
  assign in_top  = &sub_idx[SUB_W-1 -: 2];

  always_comb begin
    if (in_top) sel = SEL_W'(N_SMALL);
    else        sel = SEL_W'(sub_idx);
    hit = attr[sel];
  end

  assign route_int = !in_zone || (is_write ? hit.wr : hit.rd);
endmodule

// File: rtl/shadow_route_dec.sv
module shadow_route_dec
  import shadow_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned SEG_SHIFT  = 14,
  parameter int unsigned N_SMALL    = 12,
  parameter int unsigned BIOS_FIRST = 8,
  parameter int unsigned CTRL_BYTES = 4,
  parameter int unsigned SMRAM_BIT  = 7,
  localparam int unsigned IDX_W = $clog2(CTRL_BYTES),
  localparam int unsigned N_SEG = N_SMALL + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              route_int,
  output logic              bios_rd_shadow,
  output logic              bios_wr_shadow,
  output logic              smram_en
);
  logic [CTRL_BYTES-1:0][CTRL_W-1:0] ctrl;
  seg_attr_t [N_SEG-1:0]             attr;

  shadow_cfg_regs #(.CTRL_BYTES(CTRL_BYTES)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .ctrl  (ctrl)
  );

  shadow_seg_attr #(
    .CTRL_BYTES(CTRL_BYTES), .N_SMALL(N_SMALL),
    .BIOS_FIRST(BIOS_FIRST), .SMRAM_BIT(SMRAM_BIT)
  ) u_attr (
    .ctrl    (ctrl),
    .attr    (attr),
    .bios_rd (bios_rd_shadow),
    .bios_wr (bios_wr_shadow),
    .smram   (smram_en)
  );

  shadow_addr_sel #(
    .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .N_SMALL(N_SMALL)
  ) u_sel (
    .addr_hi   (acc_addr[ADDR_W-1:SEG_SHIFT]),
    .is_write  (acc_write),
    .attr      (attr),
    .route_int (route_int)
  );

  logic unused_lo;
  assign unused_lo = ^acc_addr[SEG_SHIFT-1:0];
endmodule

// File: rtl/shadow_route_dec_chk.sv
module shadow_route_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_idx,
  input logic [7:0]  cfg_wdata,
  input logic [19:0] acc_addr,
  input logic        route_int,
  input logic        bios_rd_shadow,
  input logic        bios_wr_shadow,
  input logic        smram_en
);
  AST_LOW_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr < 20'hC0000) |-> route_int); // R2

  AST_SMRAM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == 2'd3) |=> (smram_en == $past(cfg_wdata[7]))); // R9

  AST_BIOS_WR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == 2'd2 && cfg_wdata[0]) |=> bios_wr_shadow); // R7

  AST_BIOS_RD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == 2'd3 && cfg_wdata[1]) |=> bios_rd_shadow); // R8

  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(smram_en) && $stable(bios_rd_shadow) && $stable(bios_wr_shadow))); // R10
endmodule

bind shadow_route_dec shadow_route_dec_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_we         (cfg_we),
  .cfg_idx        (cfg_idx),
  .cfg_wdata      (cfg_wdata),
  .acc_addr       (acc_addr),
  .route_int      (route_int),
  .bios_rd_shadow (bios_rd_shadow),
  .bios_wr_shadow (bios_wr_shadow),
  .smram_en       (smram_en)
);

// File: tb/sim_shadow_route_dec.sv
`timescale 1ns/1ps
module sim_shadow_route_dec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic [19:0] acc_addr;
  logic        acc_write;
  logic        route_int, bios_rd_shadow, bios_wr_shadow, smram_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [4];

  always #5 clk = ~clk;

  shadow_route_dec u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .route_int(route_int), .bios_rd_shadow(bios_rd_shadow),
    .bios_wr_shadow(bios_wr_shadow), .smram_en(smram_en)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected routing from the requirements
  function automatic logic model_route(input logic [19:0] a, input logic w);
    logic [1:0] pr;
    int s;
    if (a < 20'hC0000) return 1'b1;
    if (a >= 20'hF0000) pr = mdl[3][1:0];
    else begin
      s  = int'((a - 20'hC0000) >> 14);
      pr = 2'(mdl[s/4] >> (2*(s%4)));
    end
    return w ? pr[0] : pr[1];
  endfunction

  task automatic wr_cfg(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[i] = d;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) wr_cfg(2'(i), 8'h00);
  endtask

  task automatic probe(input logic [19:0] a, input logic w, input string tag);
    acc_addr = a; acc_write = w;
    #1;
    check({31'd0, route_int}, {31'd0, model_route(a, w)}, tag);
  endtask

  task automatic t_reset();
    check({29'd0, bios_rd_shadow, bios_wr_shadow, smram_en}, 32'd0, "R1 flags");
    probe(20'hC0000, 1'b0, "R1 rd C0000");
    probe(20'hE4000, 1'b1, "R1 wr E4000");
    probe(20'hF8000, 1'b1, "R1 wr F8000");
    check({31'd0, route_int}, 32'd0, "R1 external");
  endtask

  task automatic t_low();
    probe(20'h00000, 1'b0, "R2 rd 00000");
    probe(20'hA0000, 1'b1, "R2 wr A0000");
    wr_cfg(2'd0, 8'hFF);
    probe(20'hBFFFF, 1'b0, "R2 rd BFFFF");
    check({31'd0, route_int}, 32'd1, "R2 internal");
    clear_all();
  endtask

  task automatic t_walk();
    for (int s = 0; s < 12; s++) begin
      logic [19:0] base;
      base = 20'hC0000 + 20'(s * 20'h4000);
      clear_all();
      wr_cfg(2'(s/4), 8'(8'h01 << (2*(s%4))));
      probe(base + 20'h2000, 1'b1, "R4 write bit");
      check({31'd0, route_int}, 32'd1, "R3 segment wr");
      probe(base, 1'b0, "R4 read stays ext");
      probe(base - 20'h1, 1'b1, "R3 lower neighbour");
      probe(base + 20'h4000, 1'b1, "R3 upper neighbour");
      wr_cfg(2'(s/4), 8'(8'h02 << (2*(s%4))));
      probe(base + 20'h3FFF, 1'b0, "R5 read bit");
      check({31'd0, route_int}, 32'd1, "R5 segment rd");
      probe(base, 1'b1, "R5 write stays ext");
    end
    clear_all();
  endtask

  task automatic t_top();
    wr_cfg(2'd3, 8'h01);
    probe(20'hF0000, 1'b1, "R6 wr F0000");
    probe(20'hFFFFF, 1'b1, "R6 wr FFFFF");
    probe(20'hF4000, 1'b0, "R6 rd ext");
    probe(20'hEFFFF, 1'b1, "R6 EFFFF untouched");
    wr_cfg(2'd3, 8'h02);
    probe(20'hFC000, 1'b0, "R6 rd FC000");
    check({31'd0, route_int}, 32'd1, "R6 rd int");
    probe(20'hF0000, 1'b1, "R6 wr ext");
    clear_all();
  endtask

  task automatic t_bios();
    wr_cfg(2'd1, 8'hFF);
    #1 check({30'd0, bios_rd_shadow, bios_wr_shadow}, 32'd0, "R7 R8 below E0000");
    wr_cfg(2'd2, 8'h04);
    #1 check({30'd0, bios_rd_shadow, bios_wr_shadow}, 32'd1, "R7 wr flag");
    wr_cfg(2'd2, 8'h80);
    #1 check({30'd0, bios_rd_shadow, bios_wr_shadow}, 32'd2, "R8 rd flag");
    wr_cfg(2'd2, 8'h00);
    wr_cfg(2'd3, 8'h02);
    #1 check({30'd0, bios_rd_shadow, bios_wr_shadow}, 32'd2, "R8 top rd");
    wr_cfg(2'd3, 8'h01);
    #1 check({30'd0, bios_rd_shadow, bios_wr_shadow}, 32'd1, "R7 top wr");
    clear_all();
  endtask

  task automatic t_smram();
    wr_cfg(2'd3, 8'h80);
    #1 check({31'd0, smram_en}, 32'd1, "R9 smram set");
    probe(20'hF0000, 1'b0, "R9 no routing effect");
    wr_cfg(2'd3, 8'h7F);
    #1 check({31'd0, smram_en}, 32'd0, "R9 smram clear");
    clear_all();
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 8'h03;
    acc_addr = 20'hC1000; acc_write = 1'b0;
    #1 check({31'd0, route_int}, 32'd0, "R10 old value before edge");
    @(negedge clk);
    cfg_we = 1'b0; mdl[0] = 8'h03;
    #1 check({31'd0, route_int}, 32'd1, "R10 new value after edge");
    // strobe low: no change
    @(negedge clk);
    cfg_idx = 2'd0; cfg_wdata = 8'h00;
    @(negedge clk);
    #1 check({31'd0, route_int}, 32'd1, "R10 no we ignored");
    cfg_idx = 2'd3; cfg_wdata = 8'h83;
    @(negedge clk);
    #1 check({29'd0, smram_en, bios_rd_shadow, bios_wr_shadow}, 32'd0, "R10 no we flags");
    clear_all();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = 2'd0; cfg_wdata = 8'h00;
    acc_addr = 20'h0; acc_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low();
    t_walk();
    t_top();
    t_bios();
    t_smram();
    t_same_cycle();
    report();
  end
endmodule